// File: doc/BRIEF.md
# Test Event Pattern Store and Playback

This block holds a set of injected calorimeter test events and replays them in place of the live detector inputs. Each event holds an electromagnetic and a hadronic energy byte for each of 81 tower channels. It also holds four bytes for each of three input cables: crossing number, spare, frame and parity. Software loads the store one 16-bit word at a time. Each word comes with a 16-bit address. One address bit chooses between tower energy words and cable control words. Other address fields choose the event, the tower or the cable, and the byte meaning. Writes are accepted whether or not playback is running.

While the test-mode input is low, the outputs follow the live inputs and the event pointer rests at event 0. While the test-mode input is high, the outputs show the stored event that the pointer selects. Each beam-crossing tick moves the pointer on by one event, and it returns to event 0 after the last of the 32 events. For each cable, a frame-check output is high when the frame byte presented at the output is a valid frame marker.

Top module: `tpm_player`

## Requirements
- R1: After reset every stored byte is zero and the event pointer is 0, so test-mode output starts as all zero with every frame-check low.
- R2: Address bit 15 chooses the target of a write. A value of 0 writes a tower energy word and a value of 1 writes a cable control word.
- R3: For an energy word, address bits 10:6 give the event. The tower channel is the seven-bit value {address bit 11, address bits 5:0}. Data bits 15:8 become the hadronic byte and data bits 7:0 become the em byte. Address bits 14:12 have no effect.
- R4: For a control word, address bits 10:6 give the event and address bits 2:0 give the control code. The code selects the cable as code/2: codes 0 and 1 go to cable 0, codes 2 and 3 to cable 1, and codes 4 and 5 to cable 2. An even code stores the crossing byte from data 7:0 and the spare byte from data 15:8. An odd code stores the frame byte from data 7:0 and the parity byte from data 15:8.
- R5: An energy write whose tower channel is above 80 changes no stored byte.
- R6: A control write with code 6 or 7 changes no stored byte.
- R7: While test mode is high, every output carries the stored bytes of the event the pointer selects. Tower t occupies bits 8t+7:8t of the em and had buses, and cable c occupies bits 8c+7:8c of each cable bus.
- R8: In test mode each tick advances the pointer by one on the next clock edge. The pointer wraps from event 31 to event 0.
- R9: While test mode is low, all outputs equal the live inputs, ticks are ignored, and the pointer is held at 0. Playback therefore always starts from event 0.
- R10: Frame-check bit c is high exactly when the frame byte output for cable c equals 8'h01. This holds in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one store word |
| wr_addr | input | 16 | Write address (space, event, channel or code) |
| wr_data | input | 16 | Write data |
| test_mode | input | 1 | 1 = play stored events, 0 = pass live inputs |
| bx_tick | input | 1 | Beam-crossing tick, advances playback |
| live_em | input | 648 | Live em energy, 8 bits per tower |
| live_had | input | 648 | Live hadronic energy, 8 bits per tower |
| live_bx | input | 24 | Live crossing byte per cable |
| live_spare | input | 24 | Live spare byte per cable |
| live_frame | input | 24 | Live frame byte per cable |
| live_parity | input | 24 | Live parity byte per cable |
| out_em | output | 648 | Selected em energy per tower |
| out_had | output | 648 | Selected hadronic energy per tower |
| out_bx | output | 24 | Selected crossing byte per cable |
| out_spare | output | 24 | Selected spare byte per cable |
| out_frame | output | 24 | Selected frame byte per cable |
| out_parity | output | 24 | Selected parity byte per cable |
| frame_ok | output | 3 | Per-cable valid frame marker flag |

## Verification
The bench fills every tower of every event, and every control code of every event, with values that are arithmetic functions of the event and the index. Playback of all 32 events followed by a wrap then shows whether the event, the tower channel and the cable were each decoded into the right place. It also shows whether the two bytes of each word went to the right field. Junk on address bits 14:12 and 5:3 tests whether those bits are really ignored. A write to channel 81, whose low six bits alias tower 17, tests the upper channel bit and the range guard. Writes with codes 6 and 7 aimed at events that are later read back test the code guard. Ticks while test mode is low, followed by re-entry, show that the pointer stays pinned at event 0. Frame bytes are set to the valid marker only in events that are a multiple of four, so frame-check must toggle across the playback sequence.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  // Address field positions are fixed by the serial word layout.
  function automatic logic is_ctrl_space(input logic [WORD_W-1:0] a);
    return a[15];
  endfunction

  function automatic logic [4:0] event_field(input logic [WORD_W-1:0] a);
    return a[10:6];
  endfunction

  function automatic logic [6:0] tower_field(input logic [WORD_W-1:0] a);
    return {a[11], a[5:0]};
  endfunction

  function automatic logic [2:0] code_field(input logic [WORD_W-1:0] a);
    return a[2:0];
  endfunction

  function automatic logic frame_marker(input logic [BYTE_W-1:0] b);
    return b == 8'h01;
  endfunction
endpackage

// File: rtl/tpm_addr_decode.sv
module tpm_addr_decode
  import tpm_pkg::*;
#(
  parameter int NUM_TOWERS = 81,
  parameter int NUM_CABLES = 3,
  parameter int EV_W       = 5,
  parameter int TW_W       = 7,
  parameter int CAB_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_addr,
  output logic              en_we,
  output logic              ctl_we,
  output logic [EV_W-1:0]   ev_idx,
  output logic [TW_W-1:0]   tw_idx,
  output logic [CAB_W-1:0]  cab_idx,
  output logic              ctl_odd
);
  logic [2:0] code;
  logic [1:0] cab_raw;
  logic       tower_in_range;
  logic       cable_in_range;

  assign code    = code_field(wr_addr);
  assign cab_raw = code[2:1];
  assign ctl_odd = code[0];
  assign ev_idx  = EV_W'(event_field(wr_addr));
  assign tw_idx  = TW_W'(tower_field(wr_addr));
  assign cab_idx = CAB_W'(cab_raw);

  assign tower_in_range = 32'(tower_field(wr_addr)) < NUM_TOWERS;
  assign cable_in_range = 32'(cab_raw) < NUM_CABLES;

  assign en_we  = wr_en && !is_ctrl_space(wr_addr) && tower_in_range;
  assign ctl_we = wr_en &&  is_ctrl_space(wr_addr) && cable_in_range;

  // R2
  space_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({en_we, ctl_we}));

  // R5
  tower_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |-> (32'(tw_idx) < NUM_TOWERS));

  // R6
  code_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |-> (32'(cab_idx) < NUM_CABLES));
endmodule

// File: rtl/tpm_event_seq.sv
module tpm_event_seq #(
  parameter int NUM_EVENTS = 32,
  parameter int EV_W       = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            test_mode,
  input  logic            bx_tick,
  output logic [EV_W-1:0] ev_cnt
);
  localparam logic [EV_W-1:0] LAST_EV = EV_W'(NUM_EVENTS - 1);

  function automatic logic [EV_W-1:0] next_event(input logic [EV_W-1:0] cur);
    return (cur == LAST_EV) ? '0 : cur + 1'b1;
  endfunction

  logic step_now;
  assign step_now = test_mode && bx_tick;

  always_ff @(posedge clk) begin
    if (!rst_n)          ev_cnt <= '0;
    else if (!test_mode) ev_cnt <= '0;
    else if (step_now)   ev_cnt <= next_event(ev_cnt);
  end

  // R8
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_now && ev_cnt == LAST_EV) |=> (ev_cnt == '0));

  // R8
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_now && ev_cnt != LAST_EV) |=> (ev_cnt == EV_W'($past(ev_cnt) + 1'b1)));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !bx_tick) |=> $stable(ev_cnt));

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |=> (ev_cnt == '0));
endmodule

// File: rtl/tpm_store.sv
module tpm_store
  import tpm_pkg::*;
#(
  parameter int NUM_EVENTS = 32,
  parameter int NUM_TOWERS = 81,
  parameter int NUM_CABLES = 3,
  parameter int EV_W       = 5,
  parameter int TW_W       = 7,
  parameter int CAB_W      = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         en_we,
  input  logic                         ctl_we,
  input  logic [EV_W-1:0]              ev_idx,
  input  logic [TW_W-1:0]              tw_idx,
  input  logic [CAB_W-1:0]             cab_idx,
  input  logic                         ctl_odd,
  input  logic [WORD_W-1:0]            wr_data,
  input  logic [EV_W-1:0]              rd_ev,
  output logic [NUM_TOWERS*BYTE_W-1:0] rd_em,
  output logic [NUM_TOWERS*BYTE_W-1:0] rd_had,
  output logic [NUM_CABLES*BYTE_W-1:0] rd_bx,
  output logic [NUM_CABLES*BYTE_W-1:0] rd_spare,
  output logic [NUM_CABLES*BYTE_W-1:0] rd_frame,
  output logic [NUM_CABLES*BYTE_W-1:0] rd_parity
);
  // Energy word: had in high byte, em in low byte.
  logic [WORD_W-1:0] en_mem  [NUM_EVENTS][NUM_TOWERS];
  // Control word pair per cable: [0] = crossing/spare, [1] = frame/parity.
  logic [WORD_W-1:0] ctl_mem [NUM_EVENTS][NUM_CABLES][2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < NUM_EVENTS; e++)
        for (int t = 0; t < NUM_TOWERS; t++)
          en_mem[e][t] <= '0;
    end else if (en_we) begin
      en_mem[ev_idx][tw_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < NUM_EVENTS; e++)
        for (int c = 0; c < NUM_CABLES; c++) begin
          ctl_mem[e][c][0] <= '0;
          ctl_mem[e][c][1] <= '0;
        end
    end else if (ctl_we) begin
      ctl_mem[ev_idx][cab_idx][ctl_odd] <= wr_data;
    end
  end

  for (genvar t = 0; t < NUM_TOWERS; t++) begin : g_tower_rd
    assign rd_em [t*BYTE_W +: BYTE_W] = en_mem[rd_ev][t][BYTE_W-1:0];
    assign rd_had[t*BYTE_W +: BYTE_W] = en_mem[rd_ev][t][WORD_W-1:BYTE_W];
  end

  for (genvar c = 0; c < NUM_CABLES; c++) begin : g_cable_rd
    assign rd_bx    [c*BYTE_W +: BYTE_W] = ctl_mem[rd_ev][c][0][BYTE_W-1:0];
    assign rd_spare [c*BYTE_W +: BYTE_W] = ctl_mem[rd_ev][c][0][WORD_W-1:BYTE_W];
    assign rd_frame [c*BYTE_W +: BYTE_W] = ctl_mem[rd_ev][c][1][BYTE_W-1:0];
    assign rd_parity[c*BYTE_W +: BYTE_W] = ctl_mem[rd_ev][c][1][WORD_W-1:BYTE_W];
  end

  // R3
  en_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> (en_mem[$past(ev_idx)][$past(tw_idx)] == $past(wr_data)));

  // R4
  ctl_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (ctl_mem[$past(ev_idx)][$past(cab_idx)][$past(ctl_odd)] == $past(wr_data)));
endmodule

// File: rtl/tpm_player.sv
module tpm_player
  import tpm_pkg::*;
#(
  parameter int NUM_EVENTS = 32,
  parameter int NUM_TOWERS = 81,
  parameter int NUM_CABLES = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [15:0]                   wr_addr,
  input  logic [15:0]                   wr_data,
  input  logic                          test_mode,
  input  logic                          bx_tick,
  input  logic [NUM_TOWERS*8-1:0]       live_em,
  input  logic [NUM_TOWERS*8-1:0]       live_had,
  input  logic [NUM_CABLES*8-1:0]       live_bx,
  input  logic [NUM_CABLES*8-1:0]       live_spare,
  input  logic [NUM_CABLES*8-1:0]       live_frame,
  input  logic [NUM_CABLES*8-1:0]       live_parity,
  output logic [NUM_TOWERS*8-1:0]       out_em,
  output logic [NUM_TOWERS*8-1:0]       out_had,
  output logic [NUM_CABLES*8-1:0]       out_bx,
  output logic [NUM_CABLES*8-1:0]       out_spare,
  output logic [NUM_CABLES*8-1:0]       out_frame,
  output logic [NUM_CABLES*8-1:0]       out_parity,
  output logic [NUM_CABLES-1:0]         frame_ok
);
  localparam int EV_W  = $clog2(NUM_EVENTS);
  localparam int TW_W  = 7;
  localparam int CAB_W = (NUM_CABLES > 1) ? $clog2(NUM_CABLES) : 1;
  localparam int TB    = NUM_TOWERS * BYTE_W;
  localparam int CB    = NUM_CABLES * BYTE_W;

  logic              en_we, ctl_we, ctl_odd;
  logic [EV_W-1:0]   ev_idx, ev_cnt;
  logic [TW_W-1:0]   tw_idx;
  logic [CAB_W-1:0]  cab_idx;
  logic [TB-1:0]     st_em, st_had;
  logic [CB-1:0]     st_bx, st_spare, st_frame, st_parity;

  tpm_addr_decode #(
    .NUM_TOWERS(NUM_TOWERS), .NUM_CABLES(NUM_CABLES),
    .EV_W(EV_W), .TW_W(TW_W), .CAB_W(CAB_W)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .en_we(en_we), .ctl_we(ctl_we), .ev_idx(ev_idx), .tw_idx(tw_idx),
    .cab_idx(cab_idx), .ctl_odd(ctl_odd)
  );

  tpm_event_seq #(.NUM_EVENTS(NUM_EVENTS), .EV_W(EV_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .bx_tick(bx_tick),
    .ev_cnt(ev_cnt)
  );

  tpm_store #(
    .NUM_EVENTS(NUM_EVENTS), .NUM_TOWERS(NUM_TOWERS), .NUM_CABLES(NUM_CABLES),
    .EV_W(EV_W), .TW_W(TW_W), .CAB_W(CAB_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .en_we(en_we), .ctl_we(ctl_we),
    .ev_idx(ev_idx), .tw_idx(tw_idx), .cab_idx(cab_idx), .ctl_odd(ctl_odd),
    .wr_data(wr_data), .rd_ev(ev_cnt),
    .rd_em(st_em), .rd_had(st_had), .rd_bx(st_bx), .rd_spare(st_spare),
    .rd_frame(st_frame), .rd_parity(st_parity)
  );

  assign out_em     = test_mode ? st_em     : live_em;
  assign out_had    = test_mode ? st_had    : live_had;
  assign out_bx     = test_mode ? st_bx     : live_bx;
  assign out_spare  = test_mode ? st_spare  : live_spare;
  assign out_frame  = test_mode ? st_frame  : live_frame;
  assign out_parity = test_mode ? st_parity : live_parity;

  for (genvar c = 0; c < NUM_CABLES; c++) begin : g_frame_chk
    assign frame_ok[c] = frame_marker(out_frame[c*BYTE_W +: BYTE_W]);
  end
endmodule

// File: tb/tpm_player_test.sv
module tpm_player_test;
  localparam int NE = 32;
  localparam int NT = 81;
  localparam int NC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_addr = '0, wr_data = '0;
  logic test_mode = 1'b0, bx_tick = 1'b0;
  logic [NT*8-1:0] live_em = '0, live_had = '0;
  logic [NC*8-1:0] live_bx = '0, live_spare = '0, live_frame = '0, live_parity = '0;
  logic [NT*8-1:0] out_em, out_had;
  logic [NC*8-1:0] out_bx, out_spare, out_frame, out_parity;
  logic [NC-1:0]   frame_ok;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tpm_player uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .test_mode(test_mode), .bx_tick(bx_tick),
    .live_em(live_em), .live_had(live_had), .live_bx(live_bx),
    .live_spare(live_spare), .live_frame(live_frame), .live_parity(live_parity),
    .out_em(out_em), .out_had(out_had), .out_bx(out_bx), .out_spare(out_spare),
    .out_frame(out_frame), .out_parity(out_parity), .frame_ok(frame_ok)
  );

  function automatic logic [15:0] en_pat(int e, int t);
    logic [7:0] had = 8'((e * 5 + t + 1) & 255);
    logic [7:0] em  = 8'(((t * 3) ^ e) & 255);
    return {had, em};
  endfunction

  // Even code: {spare, crossing}; odd code: {parity, frame}
  function automatic logic [15:0] ctl_pat(int e, int code);
    if (code % 2 == 1)
      return {8'(8'h80 + e + code), (e % 4 == 0) ? 8'h01 : 8'(e | 8'h10)};
    return {8'(e * 2 + code + 8'h20), 8'(e + code * 9 + 3)};
  endfunction

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    bx_tick = 1'b1;
    @(negedge clk);
    bx_tick = 1'b0;
    #1;
  endtask

  // Compare all outputs with stored event e (R7, R3, R4, R10)
  task automatic check_event(int e);
    for (int t = 0; t < NT; t++) begin
      logic [15:0] w = en_pat(e, t);
      chk("R7/R3", $sformatf("ev%0d em[%0d]", e, t), 16'(out_em[t*8 +: 8]), 16'(w[7:0]));
      chk("R7/R3", $sformatf("ev%0d had[%0d]", e, t), 16'(out_had[t*8 +: 8]), 16'(w[15:8]));
    end
    for (int c = 0; c < NC; c++) begin
      logic [15:0] ev_w = ctl_pat(e, 2 * c);
      logic [15:0] od_w = ctl_pat(e, 2 * c + 1);
      chk("R4", $sformatf("ev%0d bx[%0d]", e, c), 16'(out_bx[c*8 +: 8]), 16'(ev_w[7:0]));
      chk("R4", $sformatf("ev%0d spare[%0d]", e, c), 16'(out_spare[c*8 +: 8]), 16'(ev_w[15:8]));
      chk("R4", $sformatf("ev%0d frame[%0d]", e, c), 16'(out_frame[c*8 +: 8]), 16'(od_w[7:0]));
      chk("R4", $sformatf("ev%0d parity[%0d]", e, c), 16'(out_parity[c*8 +: 8]), 16'(od_w[15:8]));
      chk("R10", $sformatf("ev%0d frame_ok[%0d]", e, c), 16'(frame_ok[c]), 16'(e % 4 == 0));
    end
  endtask

  task automatic check_live(string req);
    chk(req, "em passthrough", 16'(out_em == live_em), 16'd1);
    chk(req, "had passthrough", 16'(out_had == live_had), 16'd1);
    chk(req, "bx passthrough", 16'(out_bx), 16'(live_bx));
    chk(req, "spare passthrough", 16'(out_spare), 16'(live_spare));
    chk(req, "frame passthrough", 16'(out_frame), 16'(live_frame));
    chk(req, "parity passthrough", 16'(out_parity), 16'(live_parity));
    chk("R10", "live frame_ok", 16'(frame_ok), 16'b001);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < NT; t++) begin
      live_em[t*8 +: 8]  = 8'(t + 8'h11);
      live_had[t*8 +: 8] = 8'(8'hF0 - t);
    end
    live_bx = 24'h0A0B0C; live_spare = 24'h112233;
    live_frame = 24'h020301; live_parity = 24'h5A6B7C;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_mode = 1'b1;
    #1;
    // R1: reset state of the store and pointer
    for (int t = 0; t < NT; t++) begin
      chk("R1", "reset em", 16'(out_em[t*8 +: 8]), 16'h0);
      chk("R1", "reset had", 16'(out_had[t*8 +: 8]), 16'h0);
    end
    chk("R1", "reset cable bytes", 16'(|{out_bx, out_spare, out_frame, out_parity}), 16'h0);
    chk("R1", "reset frame_ok", 16'(frame_ok), 16'h0);

    @(negedge clk);
    test_mode = 1'b0;
    #1;
    check_live("R9");

    // Fill store; junk on address bits 14:12 (energy) and 5:3 (control)
    for (int e = 0; e < NE; e++) begin
      for (int t = 0; t < NT; t++)
        wr({1'b0, 3'(e % 8), 1'(t >> 6), 5'(e), 6'(t & 63)}, en_pat(e, t));
      for (int code = 0; code < 6; code++)
        wr({1'b1, 4'(e % 16), 5'(e), 3'b101, 3'(code)}, ctl_pat(e, code));
    end
    // R5: channel 81 and 127 (low bits alias towers 17 and 63) ignored
    wr({1'b0, 3'b000, 1'b1, 5'd3, 6'd17}, 16'hDEAD);
    wr({1'b0, 3'b000, 1'b1, 5'd9, 6'd63}, 16'hBEEF);
    // R6: control codes 6 and 7 ignored
    wr({1'b1, 4'h0, 5'd4, 3'b000, 3'd6}, 16'hCAFE);
    wr({1'b1, 4'h0, 5'd5, 3'b000, 3'd7}, 16'hF00D);

    // R9: ticks ignored outside test mode, live data still shown
    tick(); tick(); tick();
    check_live("R9");

    @(negedge clk);
    test_mode = 1'b1;
    #1;
    check_event(0);   // R7 playback starts at event 0
    for (int k = 1; k <= NE + 2; k++) begin
      tick();         // R8 one event per tick, wrap 31 -> 0
      check_event(k % NE);
    end

    // R8: no tick, pointer holds
    @(negedge clk); @(negedge clk); #1;
    check_event((NE + 2) % NE);

    // R9: leave test mode, tick, re-enter: back at event 0
    @(negedge clk);
    test_mode = 1'b0;
    tick();
    check_live("R9");
    @(negedge clk);
    test_mode = 1'b1;
    #1;
    check_event(0);
    tick();
    check_event(1);

    done = 1;
    summary();
    $finish;
  end
endmodule